// File: doc/BRIEF.md
# Accumulator Operate Microinstruction Unit

This unit executes a single 12-bit operate microinstruction against a 12-bit accumulator and its one-bit link. The caller presents the instruction word, the current accumulator and link, and pulses `start`. One clock later the unit presents the new accumulator and link and raises `done` for that one cycle. The outputs keep their value until the next `start`.

The microinstruction can combine several small operations in one word: clear, complement, increment, single or double rotation through the 13-bit ring formed by the link and the accumulator, and an exchange of the accumulator's two 6-bit halves. Some rotate-bit combinations behaved differently across machine generations. A static select input picks one of three conflict behaviours, so the unit can match older or newer code.

The select input `gen_sel` is encoded as 0 = first generation, 1 = intermediate generation, 2 = late generation, and 3 = the same as 2.

Top module: `acc_operate_unit`

## Requirements
- R1: While `rst_n` is low, `acc_out`, `link_out` and `done` are all 0.
- R2: `done` is high in the cycle after a cycle with `start` high, and low otherwise. `acc_out` and `link_out` change only in a cycle where `done` is high.
- R3: A word is an operate word only when `instr[11:9]` = 3'b111 and `instr[8]` = 0. For any other word, the result equals the `acc_in` and `link_in` values sampled with `start`.
- R4: `instr[7]` clears the accumulator and `instr[6]` clears the link. After the clears, `instr[5]` inverts the accumulator and `instr[4]` inverts the link.
- R5: `instr[0]` adds one to the accumulator after the clear and complement steps. A carry out of bit 11 inverts the link.
- R6: With `instr[1]` = 0, `instr[3]` alone rotates the 13-bit ring {link, acc} right by one place, and `instr[2]` alone rotates it left by one place. The link is the ring's top bit.
- R7: With `instr[1]` = 1, `instr[3]` alone rotates the ring right by two places, and `instr[2]` alone rotates it left by two places.
- R8: With `instr[1]` = 1 and both `instr[3]` and `instr[2]` = 0, the two 6-bit halves of the accumulator are exchanged and the link is unchanged. Applying the exchange twice restores the original accumulator.
- R9: In selections 1, 2 and 3, an increment combined with any rotate bit takes effect, and the increment happens before the rotation.
- R10: In selections 0 and 1, setting both `instr[3]` and `instr[2]` gives the bitwise AND of the right-rotate and left-rotate results. The rotate distance is one place, or two places when `instr[1]` = 1.
- R11: In selections 2 and 3, setting both rotate bits with `instr[1]` = 0 rotates the ring left by three places. Setting both rotate bits with `instr[1]` = 1 leaves the rotate stage a no-op.
- R12: In selection 0, when `instr[0]` is set together with `instr[3]` or `instr[2]`, the increment is skipped and only the rotation is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Samples the operands and executes one word |
| gen_sel | input | 2 | Conflict-behaviour selection (static) |
| instr | input | 12 | Microinstruction word |
| acc_in | input | 12 | Current accumulator |
| link_in | input | 1 | Current link |
| acc_out | output | 12 | Resulting accumulator |
| link_out | output | 1 | Resulting link |
| done | output | 1 | One-cycle result-valid pulse |

## Verification
Every error inside the unit shows at the ports in the cycle right after `start`, because the datapath is a single registered stage. A fault in the stage ordering shows up only when clear, complement, increment and rotate bits are combined; for example, an increment placed after the rotation gives a result that differs in the low bits. A selection fault shows up only for words with both rotate bits set, or with an increment plus a rotate bit, so every selection is driven with those words. Faults that corrupt held state appear as outputs that move in a cycle without `done`.

// File: rtl/opr_pkg.sv
package opr_pkg;
  localparam int INSTR_W = 12;

  typedef enum logic [1:0] {
    GEN_FIRST = 2'd0,
    GEN_MID   = 2'd1,
    GEN_LATE  = 2'd2,
    GEN_LATE2 = 2'd3
  } gen_e;

  typedef struct packed {
    logic is_grp;
    logic clr_acc;
    logic clr_lnk;
    logic inv_acc;
    logic inv_lnk;
    logic rot_r;
    logic rot_l;
    logic dbl;
    logic inc;
  } opr_ctrl_t;
endpackage

// File: rtl/opr_decode.sv
module opr_decode
  import opr_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output opr_ctrl_t          ctrl
);
  always_comb begin
    ctrl.is_grp  = (instr[11:9] == 3'b111) && !instr[8];
    ctrl.clr_acc = instr[7];
    ctrl.clr_lnk = instr[6];
    ctrl.inv_acc = instr[5];
    ctrl.inv_lnk = instr[4];
    ctrl.rot_r   = instr[3];
    ctrl.rot_l   = instr[2];
    ctrl.dbl     = instr[1];
    ctrl.inc     = instr[0];
  end
endmodule

// File: rtl/opr_arith.sv
module opr_arith
  import opr_pkg::*;
#(
  parameter int W = 12
) (
  input  opr_ctrl_t    ctrl,
  input  gen_e         gen,
  input  logic [W-1:0] acc_i,
  input  logic         lnk_i,
  output logic [W-1:0] acc_o,
  output logic         lnk_o
);
  logic [W-1:0] acc_c;
  logic         lnk_c;
  logic [W:0]   sum;
  logic         inc_en;

  always_comb begin
    acc_c = ctrl.clr_acc ? '0 : acc_i;
    lnk_c = ctrl.clr_lnk ? 1'b0 : lnk_i;
    if (ctrl.inv_acc) acc_c = ~acc_c;
    if (ctrl.inv_lnk) lnk_c = ~lnk_c;
    inc_en = ctrl.inc && !((gen == GEN_FIRST) && (ctrl.rot_r || ctrl.rot_l));
    sum    = {1'b0, acc_c} + {{W{1'b0}}, 1'b1};
    acc_o  = inc_en ? sum[W-1:0] : acc_c;
    lnk_o  = lnk_c ^ (inc_en & sum[W]);
  end
endmodule

// File: rtl/opr_rotate.sv
module opr_rotate
  import opr_pkg::*;
#(
  parameter int W = 12
) (
  input  opr_ctrl_t  ctrl,
  input  gen_e       gen,
  input  logic [W:0] ring_i,
  output logic [W:0] ring_o
);
  localparam int HALF = W / 2;

  logic [W:0] rl1, rl2, rl3, rr1, rr2, swp;
  logic [W:0] rl_sel, rr_sel;
  logic       late;

  assign rl1 = {ring_i[W-1:0], ring_i[W]};
  assign rl2 = {ring_i[W-2:0], ring_i[W:W-1]};
  assign rl3 = {ring_i[W-3:0], ring_i[W:W-2]};
  assign rr1 = {ring_i[0],     ring_i[W:1]};
  assign rr2 = {ring_i[1:0],   ring_i[W:2]};

  generate
    if (W % 2 == 0) begin : g_even
      assign swp = {ring_i[W], ring_i[HALF-1:0], ring_i[W-1:HALF]};
    end else begin : g_odd
      assign swp = ring_i;
    end
  endgenerate

  always_comb begin
    late   = (gen == GEN_LATE) || (gen == GEN_LATE2);
    rl_sel = ctrl.dbl ? rl2 : rl1;
    rr_sel = ctrl.dbl ? rr2 : rr1;
    unique case ({ctrl.rot_r, ctrl.rot_l})
      2'b10:   ring_o = rr_sel;
      2'b01:   ring_o = rl_sel;
      2'b11: begin
        if (late) ring_o = ctrl.dbl ? ring_i : rl3;
        else      ring_o = rl_sel & rr_sel;
      end
      default: ring_o = ctrl.dbl ? swp : ring_i;
    endcase
  end
endmodule

// File: rtl/acc_operate_unit.sv
module acc_operate_unit
  import opr_pkg::*;
#(
  parameter int W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [1:0]         gen_sel,
  input  logic [INSTR_W-1:0] instr,
  input  logic [W-1:0]       acc_in,
  input  logic               link_in,
  output logic [W-1:0]       acc_out,
  output logic               link_out,
  output logic               done
);
  opr_ctrl_t    ctrl;
  gen_e         gen;
  logic [W-1:0] acc_a;
  logic         lnk_a;
  logic [W:0]   ring_r;
  logic [W-1:0] acc_d, acc_q;
  logic         lnk_d, lnk_q;
  logic         done_d, done_q;

  assign gen = gen_e'(gen_sel);

  opr_decode u_dec (.instr(instr), .ctrl(ctrl));

  opr_arith #(.W(W)) u_arith (
    .ctrl(ctrl), .gen(gen), .acc_i(acc_in), .lnk_i(link_in),
    .acc_o(acc_a), .lnk_o(lnk_a)
  );

  opr_rotate #(.W(W)) u_rot (
    .ctrl(ctrl), .gen(gen), .ring_i({lnk_a, acc_a}), .ring_o(ring_r)
  );

  always_comb begin
    done_d = start;
    acc_d  = acc_q;
    lnk_d  = lnk_q;
    if (start) begin
      if (ctrl.is_grp) begin
        acc_d = ring_r[W-1:0];
        lnk_d = ring_r[W];
      end else begin
        acc_d = acc_in;
        lnk_d = link_in;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      lnk_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= done_d;
      if (start) begin
        acc_q <= acc_d;
        lnk_q <= lnk_d;
      end
    end
  end

  assign acc_out  = acc_q;
  assign link_out = lnk_q;
  assign done     = done_q;
endmodule

// File: rtl/opr_unit_checker.sv
module opr_unit_checker #(
  parameter int W = 12
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic [1:0]   gen_sel,
  input logic [11:0]  instr,
  input logic [W-1:0] acc_in,
  input logic         link_in,
  input logic [W-1:0] acc_out,
  input logic         link_out,
  input logic         done
);
  localparam int HALF = W / 2;

  p_done_follows_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done == $past(start));

  p_hold_when_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(start) |-> ($stable(acc_out) && $stable(link_out)));

  p_foreign_word_passes_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(start) && ($past(instr[11:9]) != 3'b111 || $past(instr[8])))
    |-> (acc_out == $past(acc_in) && link_out == $past(link_in)));

  p_clear_both_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(start) && $past(instr) == 12'hEC0) |-> (acc_out == '0 && !link_out));

  p_half_swap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(start) && $past(instr) == 12'hE02)
    |-> (acc_out == {$past(acc_in[HALF-1:0]), $past(acc_in[W-1:HALF])}
         && link_out == $past(link_in)));

  p_late_dual_noop_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(start) && $past(gen_sel) >= 2'd2 && $past(instr) == 12'hE0E)
    |-> (acc_out == $past(acc_in) && link_out == $past(link_in)));
endmodule

bind acc_operate_unit opr_unit_checker #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .gen_sel(gen_sel), .instr(instr),
  .acc_in(acc_in), .link_in(link_in), .acc_out(acc_out),
  .link_out(link_out), .done(done)
);

// File: tb/acc_operate_unit_bench.sv
module acc_operate_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [1:0]  gen_sel;
  logic [11:0] instr;
  logic [11:0] acc_in;
  logic        link_in;
  logic [11:0] acc_out;
  logic        link_out;
  logic        done;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  typedef struct {
    logic [12:0] exp;
    string       tag;
  } item_t;
  item_t sb[$];

  always #2.5 clk = ~clk;

  acc_operate_unit u_acc_operate_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .gen_sel(gen_sel),
    .instr(instr), .acc_in(acc_in), .link_in(link_in),
    .acc_out(acc_out), .link_out(link_out), .done(done)
  );

  function automatic logic [12:0] rotl(logic [12:0] x, int n);
    for (int i = 0; i < n; i++) x = {x[11:0], x[12]};
    return x;
  endfunction

  function automatic logic [12:0] rotr(logic [12:0] x, int n);
    for (int i = 0; i < n; i++) x = {x[0], x[12:1]};
    return x;
  endfunction

  function automatic logic [12:0] ref_op(int g, logic [11:0] ins, logic [11:0] a, logic l);
    logic [12:0] r;
    int n;
    if (ins[11:9] != 3'b111 || ins[8]) return {l, a};
    if (ins[7]) a = '0;
    if (ins[6]) l = 1'b0;
    if (ins[5]) a = ~a;
    if (ins[4]) l = ~l;
    if (ins[0] && !(g == 0 && (ins[3] || ins[2]))) begin
      if (a == 12'hFFF) l = ~l;
      a = a + 12'd1;
    end
    r = {l, a};
    n = ins[1] ? 2 : 1;
    if (ins[3] && ins[2]) begin
      if (g >= 2) begin
        if (!ins[1]) r = rotl(r, 3);
      end else r = rotl(r, n) & rotr(r, n);
    end else if (ins[2]) r = rotl(r, n);
    else if (ins[3]) r = rotr(r, n);
    else if (ins[1]) r = {l, a[5:0], a[11:6]};
    return r;
  endfunction

  task automatic check(bit ok, string tag, logic [12:0] act, logic [12:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_op(int g, logic [11:0] ins, logic [11:0] a, logic l, string tag);
    item_t it;
    @(negedge clk);
    gen_sel = 2'(g);
    instr   = ins;
    acc_in  = a;
    link_in = l;
    start   = 1'b1;
    it.exp  = ref_op(g, ins, a, l);
    it.tag  = tag;
    sb.push_back(it);
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
  endtask

  task automatic check_idle(string tag);
    logic [12:0] held;
    held = {link_out, acc_out};
    instr  = 12'hEC0;
    acc_in = 12'h5A5;
    @(negedge clk);
    check(!done && {link_out, acc_out} == held, tag, {done, link_out, acc_out}, {1'b0, held});
  endtask

  // monitor: pops expected results when the pulse arrives
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (sb.size() == 0) begin
        check(1'b0, "R2 unexpected done", {link_out, acc_out}, '0);
      end else begin
        item_t it;
        it = sb.pop_front();
        check({link_out, acc_out} == it.exp, it.tag, {link_out, acc_out}, it.exp);
      end
    end
  end

  initial begin : watchdog
    while (cycles < 100000) begin
      @(posedge clk);
      cycles++;
    end
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    logic [11:0] x;
    logic [12:0] saved;
    rst_n = 1'b0; start = 1'b0; gen_sel = 2'd2;
    instr = 12'h000; acc_in = 12'hFFF; link_in = 1'b1;
    repeat (3) @(negedge clk);
    check(acc_out == 0 && !link_out && !done, "R1 reset state",
          {link_out, acc_out}, '0);
    rst_n = 1'b1;

    run_op(2, 12'h123, 12'h456, 1'b1, "R3 foreign word");
    run_op(2, 12'hF00, 12'h0F0, 1'b0, "R3 bit8 set");
    run_op(2, 12'hEC0, 12'h777, 1'b1, "R4 clear both");
    run_op(2, 12'hE30, 12'h0F0, 1'b0, "R4 invert both");
    run_op(2, 12'hEA0, 12'h123, 1'b0, "R4 clear then invert");
    run_op(2, 12'hE01, 12'hFFF, 1'b0, "R5 carry toggles link");
    run_op(2, 12'hE01, 12'h07F, 1'b1, "R5 no carry");
    run_op(2, 12'hEA1, 12'h333, 1'b0, "R5 inc after clear+invert");
    run_op(2, 12'hE04, 12'h801, 1'b0, "R6 rotate left one");
    run_op(2, 12'hE08, 12'h801, 1'b1, "R6 rotate right one");
    run_op(2, 12'hE06, 12'hC01, 1'b0, "R7 rotate left two");
    run_op(2, 12'hE0A, 12'h003, 1'b1, "R7 rotate right two");
    run_op(2, 12'hE02, 12'hABC, 1'b1, "R8 half swap");
    check_idle("R2 outputs held without start");
    run_op(2, 12'hE05, 12'hFFF, 1'b0, "R9 late inc+rotl");
    run_op(1, 12'hE09, 12'h3FF, 1'b1, "R9 mid inc+rotr");
    run_op(1, 12'hE0B, 12'h7FE, 1'b0, "R9 mid inc+double rotr");
    run_op(1, 12'hE0C, 12'h6D3, 1'b1, "R10 mid both rotate bits");
    run_op(0, 12'hE0E, 12'hB5A, 1'b0, "R10 first both double");
    run_op(2, 12'hE0C, 12'h123, 1'b1, "R11 late rotl three");
    run_op(3, 12'hE0C, 12'hF0F, 1'b0, "R11 sel3 rotl three");
    run_op(2, 12'hE0E, 12'h9C3, 1'b1, "R11 late dual no-op");
    run_op(0, 12'hE05, 12'h0FF, 1'b0, "R12 first inc suppressed rotl");
    run_op(0, 12'hE09, 12'hFFF, 1'b1, "R12 first inc suppressed rotr");
    run_op(0, 12'hE01, 12'hFFF, 1'b1, "R5 first plain inc");

    // R8 double swap cross-check at the ports
    run_op(2, 12'hE02, 12'h5C3, 1'b0, "R8 swap first pass");
    saved = {link_out, acc_out};
    run_op(2, 12'hE02, saved[11:0], saved[12], "R8 swap second pass");
    check({link_out, acc_out} == {1'b0, 12'h5C3}, "R8 double swap restores",
          {link_out, acc_out}, {1'b0, 12'h5C3});

    x = 12'h3A7;
    for (int g = 0; g < 4; g++) begin
      for (int k = 0; k < 30; k++) begin
        x = {x[10:0], x[11] ^ x[10] ^ x[7] ^ x[5]};
        run_op(g, {3'b111, 1'b0, x[7:0]}, x ^ 12'h9A5, x[3], "R10 R11 R12 sweep");
      end
    end
    check_idle("R2 idle after sweep");

    repeat (3) @(negedge clk);
    check(sb.size() == 0, "R2 all results delivered", 13'(sb.size()), '0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule